// File: doc/BRIEF.md
# BCD Gregorian Leap-Year Detector

This block decides whether a four-digit year is a leap year under the Gregorian rule. The year arrives as four packed BCD digits. The block never converts the year to binary and never divides. It reads the BCD digit bits directly to form three divisibility flags: by 4, by 100 and by 400. It then combines those flags into the leap flag.

The block is purely combinational. It is meant to sit between two registers inside a larger date path, and its outputs settle in the same cycle in which the year is presented. A separate output reports whether all four digits are legal BCD codes. When that output is low, the three flags and the leap flag still come out of the same reduced bit equations. This lets downstream logic decide for itself what to do with an illegal year.

The three divisibility flags are brought out as ports. A consumer that only needs to know "is this a century" can use them without extra logic.

Top module: `bcd_leap_detect`

## Requirements
- R1: `yearBcd` packs four BCD digits: bits 15:12 hold thousands, 11:8 hundreds, 7:4 tens and 3:0 ones.
- R2: For a year with all digits legal, `byFour` is high exactly when the value formed by the tens and ones digits is a multiple of 4.
- R3: `byHundred` is high exactly when all eight bits of the tens and ones digits are zero, whatever the upper digits hold.
- R4: For a year with all digits legal, `byFourHundred` is high exactly when `byHundred` is high and the value formed by the thousands and hundreds digits is a multiple of 4.
- R5: For a year with all digits legal, `isLeap` is high exactly when the year is a multiple of 4 and either not a multiple of 100 or a multiple of 400.
- R6: `digitsValid` is low exactly when at least one of the four digits holds a code above 9.
- R7: When any digit is illegal, the pair test is applied to each digit pair. In that test, the upper digit's bit 0 is U0 and the lower digit's bits 1 and 0 are L1 and L0. The pair test is (not U0 and not L1 and not L0) or (U0 and L1 and not L0). `byFour` is the pair test on tens/ones. `byFourHundred` is `byHundred` AND the pair test on thousands/hundreds. `isLeap` is (`byFour` AND NOT `byHundred`) OR `byFourHundred`.
- R8: All outputs follow the input in the same clock cycle, with no register on the path.
- R9: The named years give these results: 1900 is not a leap year, 2000 is, 2024 is, 2100 is not, and 0000 is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| yearBcd | input | 16 | Year as four BCD digits, thousands in the top nibble |
| isLeap | output | 1 | Year is a Gregorian leap year |
| digitsValid | output | 1 | All four digits are legal BCD codes |
| byFour | output | 1 | Year is a multiple of 4 |
| byHundred | output | 1 | Year is a multiple of 100 |
| byFourHundred | output | 1 | Year is a multiple of 400 |

## Verification
The century exception and the four-hundred override fire together on years such as 0000, 0400 and 2000. In those cycles `byHundred` and `byFourHundred` are both high, and `isLeap` must follow the override. Every 16-bit input pattern is swept one per cycle, so each such century is reached. The outputs for each pattern are compared with values the bench computes arithmetically from the decimal year. Illegal digits also coincide with the divisibility logic. Those cycles are judged by checking that `digitsValid` drops while the flags still obey the reduced pair equations.

// File: rtl/leap_pkg.sv
package leap_pkg;
  parameter int DIGIT_W = 4;
  parameter int DIGITS  = 4;
  parameter int PAIRS   = DIGITS / 2;
  parameter int YEAR_W  = DIGIT_W * DIGITS;
  parameter int MAX_DIGIT = 9;

  typedef logic [DIGIT_W-1:0] digit_t;

  // strobes handed from the datapath to the control
  typedef struct packed {
    logic lowPairDiv4;   // tens/ones pair is a multiple of 4
    logic highPairDiv4;  // thousands/hundreds pair is a multiple of 4
    logic lowPairZero;   // tens and ones digits are both zero
    logic allDigitsOk;   // no digit above nine
  } leapStrobes_t;
endpackage

// File: rtl/bcd_digit_ok.sv
module bcd_digit_ok
  import leap_pkg::*;
(
  input  digit_t digitIn,
  output logic   digitOk
);
  localparam digit_t LIMIT = digit_t'(MAX_DIGIT);

  always_comb begin
    digitOk = (digitIn <= LIMIT);
  end
endmodule

// File: rtl/bcd_pair_div4.sv
module bcd_pair_div4 (
  input  logic       upperLsb,
  input  logic [1:0] lowerLow,
  output logic       pairDiv4
);
  // even upper digit: lower must be 0, 4 or 8; odd upper digit: 2 or 6
  logic evenCase;
  logic oddCase;

  always_comb begin
    evenCase = !upperLsb && (lowerLow == 2'b00);
    oddCase  =  upperLsb && (lowerLow == 2'b10);
    pairDiv4 = evenCase || oddCase;
  end
endmodule

// File: rtl/leap_datapath.sv
module leap_datapath
  import leap_pkg::*;
(
  input  logic [YEAR_W-1:0] yearBcd,
  output leapStrobes_t      strobes
);
  digit_t            digits [DIGITS];
  logic [DIGITS-1:0] digitOkVec;
  logic [PAIRS-1:0]  pairDiv4Vec;

  // digit 0 is ones, digit DIGITS-1 is thousands
  for (genvar d = 0; d < DIGITS; d++) begin : g_digit
    assign digits[d] = yearBcd[d*DIGIT_W +: DIGIT_W];
    bcd_digit_ok u_ok (
      .digitIn (digits[d]),
      .digitOk (digitOkVec[d])
    );
  end

  // pair 0 = tens/ones, pair 1 = thousands/hundreds
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    bcd_pair_div4 u_div4 (
      .upperLsb (digits[2*p+1][0]),
      .lowerLow (digits[2*p][1:0]),
      .pairDiv4 (pairDiv4Vec[p])
    );
  end

  always_comb begin
    strobes.lowPairDiv4  = pairDiv4Vec[0];
    strobes.highPairDiv4 = pairDiv4Vec[PAIRS-1];
    strobes.lowPairZero  = (yearBcd[2*DIGIT_W-1:0] == '0);
    strobes.allDigitsOk  = &digitOkVec;
  end
endmodule

// File: rtl/leap_control.sv
module leap_control
  import leap_pkg::*;
(
  input  leapStrobes_t strobes,
  output logic         isLeap,
  output logic         digitsValid,
  output logic         byFour,
  output logic         byHundred,
  output logic         byFourHundred
);
  logic plainLeap;

  always_comb begin
    byFour        = strobes.lowPairDiv4;
    byHundred     = strobes.lowPairZero;
    byFourHundred = strobes.lowPairZero && strobes.highPairDiv4;
    plainLeap     = byFour && !byHundred;
    isLeap        = plainLeap || byFourHundred;
    digitsValid   = strobes.allDigitsOk;
  end
endmodule

// File: rtl/bcd_leap_detect.sv
module bcd_leap_detect
  import leap_pkg::*;
(
  input  logic [YEAR_W-1:0] yearBcd,
  output logic              isLeap,
  output logic              digitsValid,
  output logic              byFour,
  output logic              byHundred,
  output logic              byFourHundred
);
  leapStrobes_t strobes;

  leap_datapath u_dp (
    .yearBcd (yearBcd),
    .strobes (strobes)
  );

  leap_control u_ctl (
    .strobes       (strobes),
    .isLeap        (isLeap),
    .digitsValid   (digitsValid),
    .byFour        (byFour),
    .byHundred     (byHundred),
    .byFourHundred (byFourHundred)
  );
endmodule

// File: rtl/bcd_leap_detect_chk.sv
module bcd_leap_detect_chk (
  input logic [15:0] yearBcd,
  input logic        isLeap,
  input logic        digitsValid,
  input logic        byFour,
  input logic        byHundred,
  input logic        byFourHundred
);
  int lowVal;
  int highVal;

  always_comb begin
    lowVal  = int'(yearBcd[7:4]) * 10 + int'(yearBcd[3:0]);
    highVal = int'(yearBcd[15:12]) * 10 + int'(yearBcd[11:8]);
    if (!$isunknown({yearBcd, isLeap, digitsValid, byFour, byHundred, byFourHundred})) begin
      assert_century_low_zero_R3: assert (!byHundred || (yearBcd[7:0] == 8'h00))
        else $error("byHundred with nonzero low digits");
      assert_fourhundred_implies_century_R4: assert (!byFourHundred || byHundred)
        else $error("byFourHundred without byHundred");
      assert_override_gives_leap_R5: assert (!byFourHundred || isLeap)
        else $error("400 multiple not flagged leap");
      assert_century_exception_R5: assert (!(byHundred && !byFourHundred) || !isLeap)
        else $error("plain century flagged leap");
      assert_valid_digits_R6: assert (!digitsValid ||
          (yearBcd[15:12] <= 4'd9 && yearBcd[11:8] <= 4'd9 &&
           yearBcd[7:4] <= 4'd9 && yearBcd[3:0] <= 4'd9))
        else $error("digitsValid with illegal digit");
      assert_by_four_arith_R2: assert (!digitsValid || (byFour == ((lowVal % 4) == 0)))
        else $error("byFour disagrees with arithmetic");
      assert_high_pair_arith_R4: assert (!digitsValid || !byFourHundred || ((highVal % 4) == 0))
        else $error("byFourHundred with upper pair not a multiple of 4");
    end
  end
endmodule

bind bcd_leap_detect bcd_leap_detect_chk u_chk (
  .yearBcd       (yearBcd),
  .isLeap        (isLeap),
  .digitsValid   (digitsValid),
  .byFour        (byFour),
  .byHundred     (byHundred),
  .byFourHundred (byFourHundred)
);

// File: tb/tb_bcd_leap_detect.sv
module tb_bcd_leap_detect;
  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [15:0] yearBcd = 16'h0000;
  logic isLeap, digitsValid, byFour, byHundred, byFourHundred;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  bcd_leap_detect dut (
    .yearBcd       (yearBcd),
    .isLeap        (isLeap),
    .digitsValid   (digitsValid),
    .byFour        (byFour),
    .byHundred     (byHundred),
    .byFourHundred (byFourHundred)
  );

  task automatic report();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL R8 watchdog: actual cycles %0d expected below 150000", cycles);
      report();
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp, input logic [15:0] y);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s year %h: actual %b expected %b", tag, y, act, exp);
    end
  endtask

  function automatic logic pairTest(input logic u0, input logic [1:0] l);
    return (!u0 && l == 2'b00) || (u0 && l == 2'b10);
  endfunction

  function automatic logic [15:0] toBcd(input int y);
    return {4'((y / 1000) % 10), 4'((y / 100) % 10), 4'((y / 10) % 10), 4'(y % 10)};
  endfunction

  // full comparison of one input pattern, expected values computed here
  task automatic checkPattern(input logic [15:0] v);
    logic ok, e4, e100, e400, eLeap;
    int yr;
    ok = (v[15:12] <= 4'd9) && (v[11:8] <= 4'd9) && (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9);
    e100 = (v[7:0] == 8'h00);
    if (ok) begin
      // R1: digit order thousands..ones
      yr = int'(v[15:12]) * 1000 + int'(v[11:8]) * 100 + int'(v[7:4]) * 10 + int'(v[3:0]);
      e4    = (yr % 4) == 0;
      e400  = (yr % 400) == 0;
      eLeap = ((yr % 4) == 0 && (yr % 100) != 0) || (yr % 400) == 0;
      chk("R2 byFour", byFour, e4, v);
      chk("R4 byFourHundred", byFourHundred, e400, v);
      chk("R5 isLeap", isLeap, eLeap, v);
    end else begin
      e4    = pairTest(v[4], v[1:0]);
      e400  = e100 && pairTest(v[12], v[9:8]);
      eLeap = (e4 && !e100) || e400;
      chk("R7 byFour", byFour, e4, v);
      chk("R7 byFourHundred", byFourHundred, e400, v);
      chk("R7 isLeap", isLeap, eLeap, v);
    end
    chk("R3 byHundred", byHundred, e100, v);
    chk("R6 digitsValid", digitsValid, ok, v);
  endtask

  task automatic namedYear(input int y, input logic exp);
    @(posedge clk);
    #2 yearBcd = toBcd(y);
    #1 chk("R8 same-cycle isLeap", isLeap, exp, yearBcd);
    @(negedge clk);
    chk("R9 named year", isLeap, exp, yearBcd);
  endtask

  initial begin
    // initial state: input held at 0000
    @(negedge clk);
    chk("R9 initial 0000 leap", isLeap, 1'b1, yearBcd);
    chk("R6 initial valid", digitsValid, 1'b1, yearBcd);

    namedYear(1900, 1'b0);
    namedYear(2000, 1'b1);
    namedYear(2024, 1'b1);
    namedYear(2100, 1'b0);
    namedYear(0,    1'b1);

    // R1..R7: sweep every 16-bit pattern, legal and illegal
    for (int i = 0; i < 65536; i++) begin
      @(posedge clk);
      #2 yearBcd = 16'(i);
      @(negedge clk);
      checkPattern(yearBcd);
    end

    report();
  end
endmodule